// File: doc/BRIEF.md
# Segmented Address Translation Front-End

This block takes one 32-bit virtual access at a time and decides how it reaches a physical address. If translation is switched off in the global configuration word, the address passes straight through with every permission granted. If it is on, and the access comes from kernel mode to one of the sixteen 256 MB segments that the MMU configuration word marks as direct-mapped, the segment is remapped: the top four address bits are replaced by a base nibble taken from two packed kernel-base words. Every other access is handed to an external paged lookup (the TLB proper, which lives outside this block), and that lookup's answer is returned to the requester.

A requester offers an access with a valid/ready pair. The decision is made, and the configuration sampled, in the cycle the access is accepted. Pass-through and segment results come out registered one cycle later. A paged access raises a held lookup request toward the TLB, along with a bit that picks the instruction or data TLB. The response then carries the TLB's address, permission mask and miss flag. The response is held until the requester takes it, and no new access is taken while one is in flight.

Top module: `seg_xlate_front`

## Requirements
- R1: When bits 3:2 of `glb_cfg` are both 0, an accepted access returns `rsp_paddr` equal to `req_vaddr`, `rsp_prot` = 3'b111 (bit0 read, bit1 write, bit2 execute), `rsp_miss` = 0, and raises no TLB request, whatever the other configuration bits and the user flag hold.
- R2: With translation on, the segment number is `req_vaddr[31:28]`. A kernel access (`req_user` = 0) is direct-mapped exactly when `mmu_cfg[segment]` is 1. Otherwise it goes to the paged lookup.
- R3: For a direct-mapped segment s, the base nibble is `kbase_lo[4*s+3:4*s]` when s < 8 and `kbase_hi[4*(s-8)+3:4*(s-8)]` when s >= 8.
- R4: A direct-mapped result is `{base nibble, req_vaddr[27:0]}` with `rsp_prot` = 3'b111, `rsp_miss` = 0 and no TLB request.
- R5: A user access (`req_user` = 1) with translation on always goes to the paged lookup, even when its segment bit in `mmu_cfg` is set.
- R6: During a paged lookup, `tlb_isel` is 1 for execute accesses (`req_kind` = 2) and 0 for reads (0) and writes (1).
- R7: A paged access raises `tlb_req` in the cycle after acceptance and holds it, with `tlb_vaddr`, `tlb_kind` and `tlb_user` stable and equal to the accepted access, until `tlb_done`. The response then carries `tlb_paddr`, `tlb_prot` and `tlb_miss` as sampled with `tlb_done`.
- R8: `rsp_valid` stays high with unchanged payload until `rsp_ready` is seen. `req_ready` is 0 from acceptance until the response is taken.
- R9: A pass-through or direct-mapped access shows `rsp_valid` in the cycle right after acceptance.
- R10: In reset, `req_ready` = 1, `rsp_valid` = 0 and `tlb_req` = 0.
- R11: A `tlb_done` pulse while no lookup is outstanding produces no response and leaves the block ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Block can accept an access |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute (3 handled as read) |
| req_user | input | 1 | 1 for a user-mode access |
| glb_cfg | input | 32 | Global configuration; bits 3:2 enable translation |
| mmu_cfg | input | 32 | Bits 15:0 mark direct-mapped segments |
| kbase_lo | input | 32 | Base nibbles for segments 0 to 7 |
| kbase_hi | input | 32 | Base nibbles for segments 8 to 15 |
| tlb_req | output | 1 | Paged lookup request, held until done |
| tlb_isel | output | 1 | 1 selects the instruction TLB, 0 the data TLB |
| tlb_vaddr | output | 32 | Address to look up |
| tlb_kind | output | 2 | Access kind forwarded to the TLB |
| tlb_user | output | 1 | User flag forwarded to the TLB |
| tlb_done | input | 1 | TLB result valid |
| tlb_paddr | input | 32 | Physical address from the TLB |
| tlb_prot | input | 3 | Permission mask from the TLB |
| tlb_miss | input | 1 | TLB reports a miss or fault |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address |
| rsp_prot | output | 3 | Permission mask |
| rsp_miss | output | 1 | Miss flag |

## Verification
Two things can meet in one cycle: a finished response that the requester refuses, and the next access already waiting at the input. The bench holds `rsp_ready` low right after a pass-through result and, while the next access sits on `req_valid`, samples for several cycles that the old payload stays put and `req_ready` stays low. It then releases the stall and expects the waiting access to be accepted and answered in order. A second overlap, a stray `tlb_done` while idle, is judged by the absence of any response and by a correct answer to the paged access that follows.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    PATH_BYPASS  = 2'd0,
    PATH_SEGMENT = 2'd1,
    PATH_PAGED   = 2'd2
  } path_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } ctrl_state_e;

  // Field of the global configuration word that switches translation on
  localparam int XLATE_EN_LSB = 2;
  localparam int XLATE_EN_W   = 2;

endpackage

// File: rtl/seg_base_pick.sv
`timescale 1ns/1ps
// Selects the remap nibble for a segment out of two packed base words.
module seg_base_pick #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [ADDR_W-1:0] kbase_lo,
  input  logic [ADDR_W-1:0] kbase_hi,
  output logic [SEG_W-1:0]  base_nib
);
  localparam int NSEG = 1 << SEG_W;
  localparam int HALF = NSEG / 2;

  logic [SEG_W-1:0] nib_tab [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_nib
    if (g < HALF) begin : g_lo
      assign nib_tab[g] = kbase_lo[(g % HALF)*SEG_W +: SEG_W];
    end else begin : g_hi
      assign nib_tab[g] = kbase_hi[(g % HALF)*SEG_W +: SEG_W];
    end
  end

  assign base_nib = nib_tab[seg];

endmodule

// File: rtl/seg_classify.sv
`timescale 1ns/1ps
// Decides the path of an access and forms the untranslated or remapped address.
module seg_classify
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int CFG_W  = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        kind,
  input  logic              user,
  input  logic [CFG_W-1:0]  glb_cfg,
  input  logic [CFG_W-1:0]  mmu_cfg,
  input  logic [SEG_W-1:0]  base_nib,
  output logic [SEG_W-1:0]  seg,
  output path_e             path,
  output logic [ADDR_W-1:0] direct_paddr,
  output logic              isel
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int OFS_W = ADDR_W - SEG_W;

  logic            xl_en;
  logic [NSEG-1:0] seg_map;
  logic            seg_direct;
  logic            unused_cfg;

  assign seg        = vaddr[ADDR_W-1 -: SEG_W];
  assign seg_map    = mmu_cfg[NSEG-1:0];
  assign xl_en      = |glb_cfg[XLATE_EN_LSB +: XLATE_EN_W];
  assign seg_direct = !user && seg_map[seg];
  assign unused_cfg = ^{glb_cfg, mmu_cfg};

  always_comb begin
    if (!xl_en) begin
      path         = PATH_BYPASS;
      direct_paddr = vaddr;
    end else if (seg_direct) begin
      path         = PATH_SEGMENT;
      direct_paddr = {base_nib, vaddr[OFS_W-1:0]};
    end else begin
      path         = PATH_PAGED;
      direct_paddr = vaddr;
    end
  end

  assign isel = (kind == ACC_EXEC);

endmodule

// File: rtl/seg_ctrl.sv
`timescale 1ns/1ps
// Request/lookup/response sequencing with registered result.
module seg_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PROT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  path_e             path_in,
  input  logic [ADDR_W-1:0] direct_paddr,
  input  logic [ADDR_W-1:0] vaddr_in,
  input  logic [1:0]        kind_in,
  input  logic              user_in,
  input  logic              isel_in,
  output logic              tlb_req,
  output logic              tlb_isel,
  output logic [ADDR_W-1:0] tlb_vaddr,
  output logic [1:0]        tlb_kind,
  output logic              tlb_user,
  input  logic              tlb_done,
  input  logic [ADDR_W-1:0] tlb_paddr,
  input  logic [PROT_W-1:0] tlb_prot,
  input  logic              tlb_miss,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [PROT_W-1:0] rsp_prot,
  output logic              rsp_miss
);
  localparam logic [PROT_W-1:0] PROT_FULL = '1;

  ctrl_state_e state_q, state_d;

  logic              accept;
  logic              go_paged;
  logic              lkp_en;
  logic              rsp_en;
  logic [ADDR_W-1:0] rsp_paddr_d;
  logic [PROT_W-1:0] rsp_prot_d;
  logic              rsp_miss_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign go_paged  = (path_in == PATH_PAGED);
  assign lkp_en    = accept && go_paged;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_d = go_paged ? ST_WAIT : ST_RESP;
      ST_WAIT: if (tlb_done)  state_d = ST_RESP;
      ST_RESP: if (rsp_ready) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // response payload selection
  always_comb begin
    rsp_en      = 1'b0;
    rsp_paddr_d = direct_paddr;
    rsp_prot_d  = PROT_FULL;
    rsp_miss_d  = 1'b0;
    if (state_q == ST_WAIT) begin
      rsp_en      = tlb_done;
      rsp_paddr_d = tlb_paddr;
      rsp_prot_d  = tlb_prot;
      rsp_miss_d  = tlb_miss;
    end else if (accept && !go_paged) begin
      rsp_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_en) begin
      rsp_paddr <= rsp_paddr_d;
      rsp_prot  <= rsp_prot_d;
      rsp_miss  <= rsp_miss_d;
    end
  end

  // lookup request fields, captured once per paged access
  always_ff @(posedge clk) begin
    if (lkp_en) begin
      tlb_vaddr <= vaddr_in;
      tlb_kind  <= kind_in;
      tlb_user  <= user_in;
      tlb_isel  <= isel_in;
    end
  end

  assign tlb_req   = (state_q == ST_WAIT);
  assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/seg_xlate_front.sv
`timescale 1ns/1ps
module seg_xlate_front
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int CFG_W  = 32,
  parameter int PROT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic [CFG_W-1:0]  glb_cfg,
  input  logic [CFG_W-1:0]  mmu_cfg,
  input  logic [ADDR_W-1:0] kbase_lo,
  input  logic [ADDR_W-1:0] kbase_hi,
  output logic              tlb_req,
  output logic              tlb_isel,
  output logic [ADDR_W-1:0] tlb_vaddr,
  output logic [1:0]        tlb_kind,
  output logic              tlb_user,
  input  logic              tlb_done,
  input  logic [ADDR_W-1:0] tlb_paddr,
  input  logic [PROT_W-1:0] tlb_prot,
  input  logic              tlb_miss,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [PROT_W-1:0] rsp_prot,
  output logic              rsp_miss
);
  logic [SEG_W-1:0]  seg;
  logic [SEG_W-1:0]  base_nib;
  path_e             path;
  logic [ADDR_W-1:0] direct_paddr;
  logic              isel;

  seg_base_pick #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) i_base (
    .seg      (seg),
    .kbase_lo (kbase_lo),
    .kbase_hi (kbase_hi),
    .base_nib (base_nib)
  );

  seg_classify #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .CFG_W(CFG_W)) i_cls (
    .vaddr        (req_vaddr),
    .kind         (req_kind),
    .user         (req_user),
    .glb_cfg      (glb_cfg),
    .mmu_cfg      (mmu_cfg),
    .base_nib     (base_nib),
    .seg          (seg),
    .path         (path),
    .direct_paddr (direct_paddr),
    .isel         (isel)
  );

  seg_ctrl #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .path_in      (path),
    .direct_paddr (direct_paddr),
    .vaddr_in     (req_vaddr),
    .kind_in      (req_kind),
    .user_in      (req_user),
    .isel_in      (isel),
    .tlb_req      (tlb_req),
    .tlb_isel     (tlb_isel),
    .tlb_vaddr    (tlb_vaddr),
    .tlb_kind     (tlb_kind),
    .tlb_user     (tlb_user),
    .tlb_done     (tlb_done),
    .tlb_paddr    (tlb_paddr),
    .tlb_prot     (tlb_prot),
    .tlb_miss     (tlb_miss),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_paddr    (rsp_paddr),
    .rsp_prot     (rsp_prot),
    .rsp_miss     (rsp_miss)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
module seg_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int CFG_W  = 32,
  parameter int PROT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [1:0]        req_kind,
  input logic              req_user,
  input logic [CFG_W-1:0]  glb_cfg,
  input logic [CFG_W-1:0]  mmu_cfg,
  input logic [ADDR_W-1:0] kbase_lo,
  input logic [ADDR_W-1:0] kbase_hi,
  input logic              tlb_req,
  input logic              tlb_isel,
  input logic [ADDR_W-1:0] tlb_vaddr,
  input logic [1:0]        tlb_kind,
  input logic              tlb_user,
  input logic              tlb_done,
  input logic [ADDR_W-1:0] tlb_paddr,
  input logic [PROT_W-1:0] tlb_prot,
  input logic              tlb_miss,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [PROT_W-1:0] rsp_prot,
  input logic              rsp_miss
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int OFS_W = ADDR_W - SEG_W;
  localparam logic [PROT_W-1:0] ALL_PROT = '1;

  logic              acc;
  logic              en;
  logic [SEG_W-1:0]  sg;
  logic [NSEG-1:0]   smap;
  logic [ADDR_W-1:0] bword;
  logic [SEG_W-1:0]  exp_nib;
  logic              unused_chk;

  assign acc   = req_valid && req_ready;
  assign en    = glb_cfg[3] || glb_cfg[2];
  assign sg    = req_vaddr[ADDR_W-1 -: SEG_W];
  assign smap  = mmu_cfg[NSEG-1:0];
  assign bword = sg[SEG_W-1] ? kbase_hi : kbase_lo;
  assign exp_nib = SEG_W'(bword >> (SEG_W * int'(sg[SEG_W-2:0])));
  assign unused_chk = ^{tlb_paddr, tlb_prot, tlb_miss, tlb_user, req_kind, glb_cfg, mmu_cfg};

  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !en) |=> (rsp_valid && rsp_paddr == $past(req_vaddr) &&
                      rsp_prot == ALL_PROT && !rsp_miss && !tlb_req));

  a_r4_segment: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && en && !req_user && smap[sg]) |=>
      (rsp_valid && rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]) &&
       rsp_prot == ALL_PROT && !rsp_miss && !tlb_req));

  a_r3_base_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && en && !req_user && smap[sg]) |=>
      (rsp_paddr[ADDR_W-1 -: SEG_W] == $past(exp_nib)));

  a_r5_user_paged: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && en && req_user) |=> (tlb_req && !rsp_valid));

  a_r6_isel: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req |-> (tlb_isel == (tlb_kind == 2'd2)));

  a_r7_lookup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && !tlb_done) |=> (tlb_req && $stable(tlb_vaddr) && $stable(tlb_kind)));

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_prot) && $stable(rsp_miss)));

  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || tlb_req) |-> !req_ready);

  a_r11_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid && tlb_done) |=> (!rsp_valid && req_ready));

endmodule

bind seg_xlate_front seg_xlate_chk #(
  .ADDR_W(ADDR_W), .SEG_W(SEG_W), .CFG_W(CFG_W), .PROT_W(PROT_W)
) i_chk (.*);

// File: tb/test_seg_xlate_front.sv
`timescale 1ns/1ps
module test_seg_xlate_front;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [31:0] glb_cfg = '0;
  logic [31:0] mmu_cfg = '0;
  logic [31:0] kbase_lo = '0;
  logic [31:0] kbase_hi = '0;
  logic        tlb_req;
  logic        tlb_isel;
  logic [31:0] tlb_vaddr;
  logic [1:0]  tlb_kind;
  logic        tlb_user;
  logic        tlb_done;
  logic [31:0] tlb_paddr = '0;
  logic [2:0]  tlb_prot = '0;
  logic        tlb_miss = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_prot;
  logic        rsp_miss;

  logic resp_done = 1'b0;
  logic spur_done = 1'b0;
  logic hold_low  = 1'b0;
  logic [1:0] rdy_cnt = '0;
  bit   finished = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  assign tlb_done = resp_done | spur_done;

  always #2.5 clk = ~clk;

  seg_xlate_front i_seg_xlate_front (.*);

  typedef struct packed {
    logic [31:0] paddr;
    logic [2:0]  prot;
    logic        miss;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [31:0] tv_q[$];
  logic        ti_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  task automatic model(input logic [31:0] va, input logic user,
                       output logic paged, output exp_t e);
    logic [3:0] s;
    logic [3:0] nib;
    s = va[31:28];
    paged = 1'b0;
    if (glb_cfg[3:2] == 2'b00) begin
      e = '{paddr: va, prot: 3'b111, miss: 1'b0};            // R1
    end else if (!user && mmu_cfg[s]) begin
      nib = (s < 8) ? kbase_lo[4*s +: 4] : kbase_hi[4*(s-8) +: 4];  // R3
      e = '{paddr: {nib, va[27:0]}, prot: 3'b111, miss: 1'b0};     // R4
    end else begin
      paged = 1'b1;                                          // R2, R5
      e = '{paddr: va ^ 32'h5A00_0000, prot: va[6:4], miss: va[13]};
    end
  endtask

  task automatic issue(input logic [31:0] va, input logic [1:0] kind,
                       input logic user, input string tag);
    logic paged;
    exp_t e;
    model(va, user, paged, e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (paged) begin
      tv_q.push_back(va);
      ti_q.push_back(kind == 2'd2);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_kind  = kind;
    req_user  = user;
    @(negedge clk);
    req_valid = 1'b0;
    if (!paged) chk(rsp_valid === 1'b1, "R9", "rsp_valid after accept", 32'(rsp_valid), 32'd1);
    else        chk(tlb_req === 1'b1, "R7", "tlb_req after accept", 32'(tlb_req), 32'd1);
  endtask

  // requester back-pressure pattern
  always @(posedge clk) begin
    rdy_cnt   <= rdy_cnt + 2'd1;
    rsp_ready <= hold_low ? 1'b0 : (rdy_cnt != 2'b11);
  end

  // scoreboard monitor
  exp_t  mon_e;
  string mon_t;
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "response with nothing expected", rsp_paddr, 32'd0);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk(rsp_paddr === mon_e.paddr, mon_t, "rsp_paddr", rsp_paddr, mon_e.paddr);
        chk(rsp_prot === mon_e.prot, mon_t, "rsp_prot", 32'(rsp_prot), 32'(mon_e.prot));
        chk(rsp_miss === mon_e.miss, mon_t, "rsp_miss", 32'(rsp_miss), 32'(mon_e.miss));
      end
    end
  end

  // paged TLB responder
  initial begin
    int   cnt = 0;
    bit   seen = 0;
    logic [31:0] ev;
    logic ei;
    forever begin
      @(negedge clk);
      if (resp_done) begin
        resp_done = 1'b0;
      end else if (rst_n && tlb_req) begin
        if (!seen) begin
          seen = 1;
          cnt  = 0;
          if (tv_q.size() == 0) begin
            chk(1'b0, "R7", "lookup with nothing expected", tlb_vaddr, 32'd0);
            ev = tlb_vaddr;
            ei = tlb_isel;
          end else begin
            ev = tv_q.pop_front();
            ei = ti_q.pop_front();
          end
          chk(tlb_vaddr === ev, "R7", "tlb_vaddr", tlb_vaddr, ev);
          chk(tlb_isel === ei, "R6", "tlb_isel", 32'(tlb_isel), 32'(ei));
        end else begin
          chk(tlb_vaddr === ev, "R7", "tlb_vaddr held", tlb_vaddr, ev);
        end
        cnt++;
        if (cnt == 3) begin
          resp_done = 1'b1;
          tlb_paddr = tlb_vaddr ^ 32'h5A00_0000;
          tlb_prot  = tlb_vaddr[6:4];
          tlb_miss  = tlb_vaddr[13];
          seen = 0;
        end
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready === 1'b1, "R10", "req_ready in reset", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk(tlb_req === 1'b0, "R10", "tlb_req in reset", 32'(tlb_req), 32'd0);
    rst_n = 1'b1;

    // R1 pass-through, incl. other config bits set
    glb_cfg  = 32'h0;
    mmu_cfg  = 32'hFFFF_FFFF;
    kbase_lo = 32'h1357_9BDF;
    kbase_hi = 32'h2468_ACE0;
    issue(32'h1234_5678, 2'd0, 1'b0, "R1");
    issue(32'hF000_0ABC, 2'd2, 1'b1, "R1");
    glb_cfg = 32'hFFFF_FFF3;
    issue(32'h8765_4321, 2'd1, 1'b0, "R1");
    drain();

    // R3 / R4 every segment remapped for kernel
    glb_cfg = 32'h0000_0004;
    mmu_cfg = 32'h0000_FFFF;
    for (int s = 0; s < 16; s++) begin
      issue({s[3:0], 28'h0ABC_DE0 + 28'(s)}, 2'(s % 2), 1'b0, "R3/R4");
    end
    drain();

    // R2 / R5 / R6 mixed paths with the other enable bit
    glb_cfg = 32'h0000_0008;
    mmu_cfg = 32'h0000_8421;
    issue(32'h5000_1230, 2'd0, 1'b0, "R2");
    issue(32'h6000_2070, 2'd0, 1'b0, "R2");
    issue(32'hA000_3050, 2'd1, 1'b1, "R5");
    issue(32'h3000_0010, 2'd2, 1'b0, "R6");
    issue(32'h0000_2060, 2'd2, 1'b1, "R6");
    issue(32'hF000_0440, 2'd1, 1'b0, "R4");
    issue(32'hF123_4567, 2'd2, 1'b0, "R2");
    issue(32'h0ABC_2000, 2'd3, 1'b0, "R4");
    drain();

    // R8 stalled response while next access waits
    glb_cfg  = 32'h0;
    hold_low = 1'b1;
    issue(32'h0222_0000, 2'd0, 1'b0, "R8");
    fork
      issue(32'h0333_0000, 2'd0, 1'b0, "R8");
    join_none
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1, "R8", "valid held", 32'(rsp_valid), 32'd1);
      chk(rsp_paddr === 32'h0222_0000, "R8", "payload held", rsp_paddr, 32'h0222_0000);
      chk(req_ready === 1'b0, "R8", "busy while held", 32'(req_ready), 32'd0);
    end
    hold_low = 1'b0;
    wait fork;
    drain();

    // R11 stray completion while idle
    glb_cfg = 32'h0000_000C;
    mmu_cfg = 32'h0;
    @(negedge clk);
    tlb_paddr = 32'hDEAD_BEEF;
    spur_done = 1'b1;
    @(negedge clk);
    spur_done = 1'b0;
    chk(rsp_valid === 1'b0, "R11", "no response from stray done", 32'(rsp_valid), 32'd0);
    chk(req_ready === 1'b1, "R11", "still ready", 32'(req_ready), 32'd1);
    issue(32'h4000_0070, 2'd0, 1'b0, "R11");
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7/R8 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule